// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches eight already-synchronized GPIO lines and turns activity on them into interrupt requests. Each line can be set up on its own to respond to a high level, a low level, a rising edge, a falling edge or to both edges. Edge events are held in a per-line latch until software clears them. Level events are not latched: they track the input. A raw status vector, a status vector gated by per-line enables and a single OR-combined interrupt output are provided.

Software controls the block through a simple register port. Each write cycle presents an address, a data byte and a write strobe. Read data is combinational on the address. Each configuration register holds one bit per line. Within a register, bit i always belongs to line i.

Every line runs a two-state machine:
- `LN_QUIET` means no event is held. It moves to `LN_PENDING` on a qualifying edge.
- `LN_PENDING` means an edge event is held. It returns to `LN_QUIET` on a clear that is not accompanied by a new edge.
- While the line is in level mode, the machine is forced into `LN_QUIET`.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, all configuration registers read 0, raw status is 0 and `irq` is 0.
- R2: When the line's sense bit (register 0x404) is 1, the line is in level mode. Its raw status bit equals 1 whenever the input matches the polarity bit (register 0x40C): 1 selects high, 0 selects low. This follows `line_in` in the same cycle.
- R3: When the sense bit is 0 and the both-edges bit (register 0x408) is 0, the line is in single-edge mode. Polarity 1 latches on a rising edge and polarity 0 latches on a falling edge. An edge is the difference between the input sampled at one clock and at the previous clock, and the latch sets at that clock.
- R4: When the sense bit is 0 and the both-edges bit is 1, either transition sets the latch and the polarity bit is ignored.
- R5: Writing 1 to bit i at address 0x41C clears the held edge event of line i. Writing 0 leaves that bit unchanged.
- R6: An edge and a clear arriving for the same line in the same cycle leave the status set.
- R7: Masked status equals raw status ANDed with the enable register (0x410). `irq` is the OR of all masked status bits.
- R8: Changing enable bits never changes raw status.
- R9: Raw status reads at 0x414 and masked status at 0x418. Both are read-only, and writes to them are ignored. The clear register 0x41C reads 0. Any other address reads 0.
- R10: A level event drops as soon as the input leaves its active level, with no clear needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N_LINES | Synchronized GPIO line levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | N_LINES | Register write data |
| reg_rdata | output | N_LINES | Register read data for `reg_addr` |
| raw_status | output | N_LINES | Per-line event status before enable |
| masked_status | output | N_LINES | Raw status ANDed with enables |
| irq | output | 1 | OR of all masked status bits |

## Verification
Directed phases exercise specific trigger types:
- Single-edge stimulus with one line per polarity distinguishes rising from falling detection.
- Both-edge stimulus run under both polarity settings shows that polarity is ignored in that mode.
- Level-high and level-low lines are toggled without any clear, which separates latched behaviour from tracking behaviour.
- Clear writes with mixed 0 and 1 bits, plus a clear issued in the same cycle as a new edge, test the set/clear priority.

A long stretch of random line activity, mixed with random configuration and clear writes, is then compared against a behavioural model on every cycle, including mid-run mode switches.

// File: rtl/gid_pkg.sv
package gid_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_SENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFF_BOTH  = 12'h408;
    localparam logic [ADDR_W-1:0] OFF_POL   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFF_EN    = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFF_MSK   = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h41C;

    // per-line event state
    typedef enum logic {
        LN_QUIET   = 1'b0,
        LN_PENDING = 1'b1
    } line_state_e;

    // decoded register selection
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SENSE,
        SEL_BOTH,
        SEL_POL,
        SEL_EN,
        SEL_RAW,
        SEL_MSK,
        SEL_CLR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_SENSE: s = SEL_SENSE;
            OFF_BOTH:  s = SEL_BOTH;
            OFF_POL:   s = SEL_POL;
            OFF_EN:    s = SEL_EN;
            OFF_RAW:   s = SEL_RAW;
            OFF_MSK:   s = SEL_MSK;
            OFF_CLR:   s = SEL_CLR;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gid_regs.sv
module gid_regs
    import gid_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  reg_sel_e           reg_sel,
    input  logic [N_LINES-1:0] reg_wdata,
    input  logic [N_LINES-1:0] raw_status,
    input  logic [N_LINES-1:0] masked_status,
    output logic [N_LINES-1:0] sense_q,
    output logic [N_LINES-1:0] both_q,
    output logic [N_LINES-1:0] pol_q,
    output logic [N_LINES-1:0] en_q,
    output logic [N_LINES-1:0] clr_pulse,
    output logic [N_LINES-1:0] reg_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_SENSE: sense_q <= reg_wdata;
                SEL_BOTH:  both_q  <= reg_wdata;
                SEL_POL:   pol_q   <= reg_wdata;
                SEL_EN:    en_q    <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // clear is a one-cycle strobe, never stored
    always_comb begin
        clr_pulse = '0;
        if (reg_wr && reg_sel == SEL_CLR) clr_pulse = reg_wdata;
    end

    always_comb begin
        unique case (reg_sel)
            SEL_SENSE: reg_rdata = sense_q;
            SEL_BOTH:  reg_rdata = both_q;
            SEL_POL:   reg_rdata = pol_q;
            SEL_EN:    reg_rdata = en_q;
            SEL_RAW:   reg_rdata = raw_status;
            SEL_MSK:   reg_rdata = masked_status;
            SEL_CLR:   reg_rdata = '0;
            SEL_NONE:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gid_line.sv
module gid_line
    import gid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic sense,
    input  logic both,
    input  logic pol,
    input  logic clr,
    output logic raw
);

    line_state_e state_q, state_d;
    logic        prev_q;
    logic        edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= line_in;
    end

    // qualifying transition for the selected edge type
    always_comb begin
        if (both)     edge_hit = line_in ^ prev_q;
        else if (pol) edge_hit = line_in & ~prev_q;
        else          edge_hit = ~line_in & prev_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_QUIET;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (sense) begin
            state_d = LN_QUIET;
        end else begin
            unique case (state_q)
                LN_QUIET:   if (edge_hit) state_d = LN_PENDING;
                LN_PENDING: if (clr && !edge_hit) state_d = LN_QUIET;
            endcase
        end
    end

    // outputs
    always_comb begin
        if (sense) raw = (line_in == pol);
        else       raw = (state_q == LN_PENDING);
    end

endmodule

// File: rtl/gid_status.sv
module gid_status #(
    parameter int N_LINES = 8
) (
    input  logic [N_LINES-1:0] raw_status,
    input  logic [N_LINES-1:0] en_q,
    output logic [N_LINES-1:0] masked_status,
    output logic               irq
);

    always_comb begin
        masked_status = raw_status & en_q;
        irq           = |masked_status;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gid_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LINES-1:0]       line_in,
    input  logic                     reg_wr,
    input  logic [gid_pkg::ADDR_W-1:0] reg_addr,
    input  logic [N_LINES-1:0]       reg_wdata,
    output logic [N_LINES-1:0]       reg_rdata,
    output logic [N_LINES-1:0]       raw_status,
    output logic [N_LINES-1:0]       masked_status,
    output logic                     irq
);

    reg_sel_e           reg_sel;
    logic [N_LINES-1:0] sense_q, both_q, pol_q, en_q, clr_pulse;

    assign reg_sel = decode_addr(reg_addr);

    gid_regs #(.N_LINES(N_LINES)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .raw_status    (raw_status),
        .masked_status (masked_status),
        .sense_q       (sense_q),
        .both_q        (both_q),
        .pol_q         (pol_q),
        .en_q          (en_q),
        .clr_pulse     (clr_pulse),
        .reg_rdata     (reg_rdata)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        gid_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (line_in[i]),
            .sense   (sense_q[i]),
            .both    (both_q[i]),
            .pol     (pol_q[i]),
            .clr     (clr_pulse[i]),
            .raw     (raw_status[i])
        );
    end

    gid_status #(.N_LINES(N_LINES)) u_status (
        .raw_status    (raw_status),
        .en_q          (en_q),
        .masked_status (masked_status),
        .irq           (irq)
    );

endmodule

// File: rtl/gid_checker.sv
module gid_checker
    import gid_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_LINES-1:0]   line_in,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [N_LINES-1:0]   reg_wdata,
    input logic [N_LINES-1:0]   reg_rdata,
    input logic [N_LINES-1:0]   raw_status,
    input logic [N_LINES-1:0]   masked_status,
    input logic                 irq,
    input logic [N_LINES-1:0]   sense_q,
    input logic [N_LINES-1:0]   pol_q,
    input logic [N_LINES-1:0]   en_q
);

    // R1: nothing is flagged while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r1: assert (raw_status == '0 && !irq);
        end
    end

    // R7: with no enabled raw event the interrupt is low
    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_status & en_q) == '0) |-> !irq);

    // R7: masked status as seen against the enable readback
    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_EN) |-> (masked_status == (raw_status & reg_rdata)));

    // R9: clear register reads zero
    p_clrrd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_CLR) |-> (reg_rdata == '0));

    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        // R2: level lines track input against polarity
        p_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
            sense_q[i] |-> (raw_status[i] == (line_in[i] == pol_q[i])));

        // R5: a held edge event survives without a clear for this line
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!sense_q[i] && raw_status[i]
             && !(reg_wr && reg_addr == OFF_CLR && reg_wdata[i])
             && !(reg_wr && reg_addr == OFF_SENSE)) |=> raw_status[i]);
    end

endmodule

bind gpio_irq_detect gid_checker #(.N_LINES(N_LINES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_in       (line_in),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq           (irq),
    .sense_q       (sense_q),
    .pol_q         (pol_q),
    .en_q          (en_q)
);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] line_in = '0;
    logic         reg_wr = 1'b0;
    logic [11:0]  reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata, raw_status, masked_status;
    logic         irq;

    always #2 clk = ~clk;

    gpio_irq_detect #(.N_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
    );

    // behavioural reference state
    bit m_sense[N], m_both[N], m_pol[N], m_en[N], m_prev[N], m_pend[N];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "R1";

    function automatic logic [N-1:0] exp_raw(input logic [N-1:0] lines);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = m_sense[i] ? (lines[i] == m_pol[i]) : m_pend[i];
        return r;
    endfunction

    function automatic logic [N-1:0] pack(input bit a[N]);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = a[i];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_rd(input logic [11:0] a, input logic [N-1:0] lines);
        case (a)
            12'h404: return pack(m_sense);
            12'h408: return pack(m_both);
            12'h40C: return pack(m_pol);
            12'h410: return pack(m_en);
            12'h414: return exp_raw(lines);
            12'h418: return exp_raw(lines) & pack(m_en);
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_sense[i] = 0; m_both[i] = 0; m_pol[i] = 0;
            m_en[i] = 0; m_prev[i] = 0; m_pend[i] = 0;
        end
    endtask

    task automatic model_clock(input logic [N-1:0] lines, input bit wr,
                               input logic [11:0] a, input logic [N-1:0] wd);
        for (int i = 0; i < N; i++) begin
            bit ev;
            bit clr;
            if (m_both[i]) ev = lines[i] != m_prev[i];
            else if (m_pol[i]) ev = lines[i] && !m_prev[i];
            else ev = !lines[i] && m_prev[i];
            clr = wr && a == 12'h41C && wd[i];
            if (m_sense[i]) m_pend[i] = 0;
            else if (ev) m_pend[i] = 1;
            else if (clr) m_pend[i] = 0;
            m_prev[i] = lines[i];
        end
        if (wr) begin
            for (int i = 0; i < N; i++) begin
                case (a)
                    12'h404: m_sense[i] = wd[i];
                    12'h408: m_both[i]  = wd[i];
                    12'h40C: m_pol[i]   = wd[i];
                    12'h410: m_en[i]    = wd[i];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic step(input logic [N-1:0] lines, input bit wr,
                        input logic [11:0] a, input logic [N-1:0] wd);
        logic [N-1:0] er;
        @(negedge clk);
        line_in = lines; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        er = exp_raw(lines);
        chk("raw_status", raw_status, er);
        chk("masked_status", masked_status, er & pack(m_en));
        chk("irq", {7'b0, irq}, {7'b0, |(er & pack(m_en))});
        chk("reg_rdata", reg_rdata, exp_rd(a, lines));
        @(posedge clk);
        model_clock(lines, wr, a, wd);
    endtask

    task automatic wr_reg(input logic [N-1:0] lines, input logic [11:0] a, input logic [N-1:0] wd);
        step(lines, 1'b1, a, wd);
    endtask

    task automatic idle(input logic [N-1:0] lines, input logic [11:0] a);
        step(lines, 1'b0, a, '0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: reset values while held in reset
        repeat (3) @(negedge clk);
        chk("reset raw", raw_status, '0);
        chk("reset irq", {7'b0, irq}, '0);
        @(negedge clk) rst_n = 1'b1;
        tag = "R1";
        idle('0, 12'h404); idle('0, 12'h408); idle('0, 12'h40C);
        idle('0, 12'h410); idle('0, 12'h414); idle('0, 12'h418);

        // R9: map readback and read-only addresses
        tag = "R9";
        wr_reg('0, 12'h404, 8'hA5); idle('0, 12'h404);
        wr_reg('0, 12'h404, 8'h00);
        wr_reg('0, 12'h414, 8'hFF); idle('0, 12'h414);
        wr_reg('0, 12'h418, 8'hFF); idle('0, 12'h418);
        idle('0, 12'h41C); idle('0, 12'h7FC);

        // R3: line0 rising, line1 falling
        tag = "R3";
        wr_reg('0, 12'h410, 8'hFF);
        wr_reg('0, 12'h40C, 8'h01);
        idle(8'h02, 12'h414);
        idle(8'h02, 12'h414);
        idle(8'h03, 12'h414);
        idle(8'h03, 12'h414);
        idle(8'h01, 12'h414);
        idle(8'h00, 12'h414);
        idle(8'h00, 12'h418);

        // R5: clear with zero bits, then with ones
        tag = "R5";
        wr_reg(8'h00, 12'h41C, 8'h00); idle(8'h00, 12'h414);
        wr_reg(8'h00, 12'h41C, 8'h01); idle(8'h00, 12'h414);
        wr_reg(8'h00, 12'h41C, 8'h02); idle(8'h00, 12'h414);

        // R6: new edge coincides with clear
        tag = "R6";
        idle(8'h00, 12'h414);
        wr_reg(8'h01, 12'h41C, 8'h01); idle(8'h01, 12'h414);
        wr_reg(8'h01, 12'h41C, 8'h01); idle(8'h01, 12'h414);

        // R4: line2 both edges under polarity 0 and 1
        tag = "R4";
        wr_reg(8'h01, 12'h408, 8'h04);
        idle(8'h05, 12'h414); wr_reg(8'h05, 12'h41C, 8'h04);
        idle(8'h01, 12'h414); wr_reg(8'h01, 12'h41C, 8'h04);
        wr_reg(8'h01, 12'h40C, 8'h05);
        idle(8'h05, 12'h414); wr_reg(8'h05, 12'h41C, 8'h04);
        idle(8'h01, 12'h414); idle(8'h01, 12'h414);

        // R2 / R10: line3 level-high, line4 level-low
        tag = "R2";
        wr_reg(8'h01, 12'h40C, 8'h08);
        wr_reg(8'h01, 12'h404, 8'h18);
        idle(8'h01, 12'h414); idle(8'h09, 12'h414); idle(8'h19, 12'h418);
        tag = "R10";
        idle(8'h11, 12'h414); idle(8'h01, 12'h414); idle(8'h09, 12'h414);

        // R7 / R8: enable gating leaves raw untouched
        tag = "R7";
        wr_reg(8'h09, 12'h410, 8'h00); idle(8'h09, 12'h418);
        tag = "R8";
        wr_reg(8'h09, 12'h410, 8'h08); idle(8'h09, 12'h414);
        wr_reg(8'h09, 12'h410, 8'hFF); idle(8'h09, 12'h418);

        // random mix of activity and configuration
        tag = "R3";
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] ln;
            int sel;
            logic [11:0] a;
            ln = N'($urandom);
            sel = $urandom_range(0, 7);
            a = 12'h404 + 12'(4 * sel);
            if ($urandom_range(0, 3) == 0) wr_reg(ln, a, N'($urandom));
            else idle(ln, a);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule